// File: doc/BRIEF.md
# Supply-Plug Reset and Watchdog Generator

This block produces a reset for an external processor. In its default one-shot mode it watches an input-supply-valid flag. Once that flag has stayed high for a settle interval, it raises a pending output. It then issues one active-low reset pulse, either when a long hold interval runs out or earlier when the processor drives the request pin. After that it stays quiet until the supply is removed and plugged in again.

With the watchdog enable high, the block runs whether or not the supply is present. It raises pending and issues a reset pulse every hold interval. The request pin then serves as a clear: a rising edge that lands early enough restarts the interval. A clear that arrives too close to expiry has no effect. The pulse width depends on whether the system runs from battery when the pulse starts.

All intervals are counted in ticks of a one-cycle strobe, nominally one per microsecond, and every interval is a parameter. The reset output models the pull-down of an open-drain pin: it is low while the reset is asserted.

Top module: `smart_rst_wdog`

## Requirements
- R1: While reset is held and on the first cycle after release, pend_o is 0 and rst_req_n_o is 1.
- R2: In one-shot mode, pend_o rises on the (SETTLE_TICKS+1)th rising clock edge after supply_ok_i is first sampled high, with one tick per cycle. If supply_ok_i falls before that, pend_o stays low and a later plug-in restarts the full settle interval.
- R3: In one-shot mode the pulse starts HOLD_TICKS ticks after pend_o rose, or on the third clock edge after req_clr_i goes high if that is earlier. A request that lands on the expiry edge yields exactly one pulse.
- R4: pend_o falls on the same edge that rst_req_n_o goes low. In one-shot mode no further pulse or pending occurs until supply_ok_i has been low and high again.
- R5: The pulse lasts PULSE_SUP_TICKS ticks when bat_mode_i is 0 at pulse start and PULSE_BAT_TICKS ticks when it is 1.
- R6: When wdog_en_i rises, pend_o goes high on the second clock edge, independent of supply_ok_i. Pulses then repeat every HOLD_TICKS ticks, counted from pend_o rising. pend_o returns high on the edge where rst_req_n_o is released.
- R7: In watchdog mode, a rising edge of the synchronized request restarts the hold count from zero if the count is at most HOLD_TICKS-GUARD_TICKS when the edge is seen. If the count is higher, the edge is ignored and the pulse comes at expiry.
- R8: Clearing wdog_en_i drops pend_o on the next edge and returns to one-shot mode. If supply_ok_i is high, a fresh settle interval follows, with pend_o rising on edge SETTLE_TICKS+2.
- R9: All intervals advance only on clock edges where tick_i is 1.
- R10: In one-shot mode, supply_ok_i low on an edge forces pend_o low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base strobe |
| supply_ok_i | input | 1 | Input supply valid |
| req_clr_i | input | 1 | Asynchronous reset request (one-shot) or clear (watchdog) |
| wdog_en_i | input | 1 | Selects watchdog mode when 1 |
| bat_mode_i | input | 1 | Running from battery; selects the long pulse |
| pend_o | output | 1 | Reset pending, push-pull |
| rst_req_n_o | output | 1 | Reset pulse, low while asserted |

## Verification
Two functions can act on the same edge: the hold-interval expiry and the request/clear path. In one-shot mode the bench times the request so that its synchronized level reaches the controller exactly on the expiry edge, and again one edge earlier and one edge later. It then checks that the pulse starts at the earlier of the two moments and that only one pulse follows. In watchdog mode the clear is placed so that it is seen at count HOLD_TICKS-GUARD_TICKS, which must restart the interval, and at one count later, which must leave the expiry pulse in place. The judgement uses the measured edge count from pend_o rising to the pulse.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  typedef enum logic [2:0] {
    RG_IDLE   = 3'd0,
    RG_SETTLE = 3'd1,
    RG_ARMED  = 3'd2,
    RG_PULSE  = 3'd3,
    RG_SPENT  = 3'd4
  } rg_state_e;
endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstgen_timer.sv
module rstgen_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i | (run_i & tick_i);
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rstgen_fsm.sv
module rstgen_fsm
  import rstgen_pkg::*;
#(
  parameter int CW              = 8,
  parameter int SETTLE_TICKS    = 20,
  parameter int HOLD_TICKS      = 200,
  parameter int GUARD_TICKS     = 10,
  parameter int PULSE_SUP_TICKS = 5,
  parameter int PULSE_BAT_TICKS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          supply_ok_i,
  input  logic          req_i,
  input  logic          wdog_en_i,
  input  logic          bat_mode_i,
  input  logic [CW-1:0] cnt_i,
  output logic          cnt_clr_o,
  output logic          cnt_run_o,
  output rg_state_e     state_o
);
  localparam logic [CW-1:0] SettleLast = CW'(SETTLE_TICKS - 1);
  localparam logic [CW-1:0] HoldLast   = CW'(HOLD_TICKS - 1);
  localparam logic [CW-1:0] ClearLimit = CW'(HOLD_TICKS - GUARD_TICKS);
  localparam logic [CW-1:0] SupLast    = CW'(PULSE_SUP_TICKS - 1);
  localparam logic [CW-1:0] BatLast    = CW'(PULSE_BAT_TICKS - 1);

  rg_state_e st_q, st_d;
  logic      mode_q;
  logic      wide_q, wide_d;
  logic      req_q;

  logic mode_chg, req_rise, settle_hit, hold_hit, width_hit, clear_ok;

  always_comb begin
    mode_chg   = wdog_en_i ^ mode_q;
    req_rise   = req_i & ~req_q;
    settle_hit = tick_i & (cnt_i == SettleLast);
    hold_hit   = tick_i & (cnt_i == HoldLast);
    width_hit  = tick_i & (cnt_i == (wide_q ? BatLast : SupLast));
    clear_ok   = req_rise & (cnt_i <= ClearLimit);
  end

  always_comb begin
    st_d      = st_q;
    wide_d    = wide_q;
    cnt_clr_o = 1'b0;
    if (st_q != RG_PULSE && mode_chg) begin
      st_d      = RG_IDLE;
      cnt_clr_o = 1'b1;
    end else begin
      unique case (st_q)
        RG_IDLE: begin
          cnt_clr_o = 1'b1;
          if (wdog_en_i)        st_d = RG_ARMED;
          else if (supply_ok_i) st_d = RG_SETTLE;
        end
        RG_SETTLE: begin
          if (!supply_ok_i) begin
            st_d      = RG_IDLE;
            cnt_clr_o = 1'b1;
          end else if (settle_hit) begin
            st_d      = RG_ARMED;
            cnt_clr_o = 1'b1;
          end
        end
        RG_ARMED: begin
          if (!wdog_en_i && !supply_ok_i) begin
            st_d      = RG_IDLE;
            cnt_clr_o = 1'b1;
          end else if ((!wdog_en_i && req_i) || hold_hit) begin
            st_d      = RG_PULSE;
            wide_d    = bat_mode_i;
            cnt_clr_o = 1'b1;
          end else if (wdog_en_i && clear_ok) begin
            cnt_clr_o = 1'b1;
          end
        end
        RG_PULSE: begin
          if (width_hit) begin
            st_d      = (mode_q && wdog_en_i) ? RG_ARMED : RG_SPENT;
            cnt_clr_o = 1'b1;
          end
        end
        RG_SPENT: begin
          if (!supply_ok_i) begin
            st_d      = RG_IDLE;
            cnt_clr_o = 1'b1;
          end
        end
        default: begin
          st_d      = RG_IDLE;
          cnt_clr_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RG_IDLE;
      mode_q <= 1'b0;
      wide_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= wdog_en_i;
      wide_q <= wide_d;
      req_q  <= req_i;
    end
  end

  assign cnt_run_o = (st_q == RG_SETTLE) | (st_q == RG_ARMED) | (st_q == RG_PULSE);
  assign state_o   = st_q;
endmodule

// File: rtl/smart_rst_wdog.sv
module smart_rst_wdog
  import rstgen_pkg::*;
#(
  parameter int SETTLE_TICKS    = 150000,
  parameter int HOLD_TICKS      = 4000000,
  parameter int GUARD_TICKS     = 100,
  parameter int PULSE_SUP_TICKS = 25,
  parameter int PULSE_BAT_TICKS = 50,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic req_clr_i,
  input  logic wdog_en_i,
  input  logic bat_mode_i,
  output logic pend_o,
  output logic rst_req_n_o
);
  localparam int MaxA = (SETTLE_TICKS > HOLD_TICKS) ? SETTLE_TICKS : HOLD_TICKS;
  localparam int MaxB = (PULSE_SUP_TICKS > PULSE_BAT_TICKS) ? PULSE_SUP_TICKS : PULSE_BAT_TICKS;
  localparam int MaxT = (MaxA > MaxB) ? MaxA : MaxB;
  localparam int CW   = $clog2(MaxT + 1);

  logic          req_s;
  logic          cnt_clr, cnt_run;
  logic [CW-1:0] cnt;
  rg_state_e     state;

  rstgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(req_clr_i), .q_o(req_s)
  );

  rstgen_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .run_i(cnt_run),
    .tick_i(tick_i), .cnt_o(cnt)
  );

  rstgen_fsm #(
    .CW(CW), .SETTLE_TICKS(SETTLE_TICKS), .HOLD_TICKS(HOLD_TICKS),
    .GUARD_TICKS(GUARD_TICKS), .PULSE_SUP_TICKS(PULSE_SUP_TICKS),
    .PULSE_BAT_TICKS(PULSE_BAT_TICKS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .supply_ok_i(supply_ok_i),
    .req_i(req_s), .wdog_en_i(wdog_en_i), .bat_mode_i(bat_mode_i),
    .cnt_i(cnt), .cnt_clr_o(cnt_clr), .cnt_run_o(cnt_run), .state_o(state)
  );

  assign pend_o      = (state == RG_ARMED);
  assign rst_req_n_o = (state != RG_PULSE);
endmodule

// File: rtl/smart_rst_wdog_chk.sv
module smart_rst_wdog_chk #(
  parameter int PULSE_SUP_TICKS = 25,
  parameter int PULSE_BAT_TICKS = 50
) (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic supply_ok_i,
  input logic wdog_en_i,
  input logic bat_mode_i,
  input logic pend_o,
  input logic rst_req_n_o
);
  localparam int PMax = (PULSE_SUP_TICKS > PULSE_BAT_TICKS) ? PULSE_SUP_TICKS : PULSE_BAT_TICKS;
  localparam int TW   = $clog2(PMax + 2);

  logic [TW-1:0] tk_q;
  logic          wide_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tk_q   <= '0;
      wide_q <= 1'b0;
    end else if (rst_req_n_o == 1'b0 && $past(rst_req_n_o) == 1'b1) begin
      tk_q   <= TW'(tick_i);
      wide_q <= $past(bat_mode_i);
    end else if (!rst_req_n_o && tick_i) begin
      tk_q   <= tk_q + 1'b1;
    end
  end

  // R10: one-shot mode with no supply leaves nothing pending
  a_r10_no_pend_without_supply: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!supply_ok_i) && $past(!wdog_en_i)) |-> !pend_o);

  // R4: pending is withdrawn on the edge the pulse begins
  a_r4_pend_falls_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req_n_o) |-> $fell(pend_o));

  // R5: pulse length in ticks follows the power mode at pulse start
  a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_n_o) |->
      (tk_q == (wide_q ? TW'(PULSE_BAT_TICKS) : TW'(PULSE_SUP_TICKS))));

  // R6: watchdog re-arms as the pulse ends
  a_r6_rearm_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_req_n_o) && $past(wdog_en_i) && $past(wdog_en_i, 2)) |-> pend_o);
endmodule

bind smart_rst_wdog smart_rst_wdog_chk #(
  .PULSE_SUP_TICKS(PULSE_SUP_TICKS), .PULSE_BAT_TICKS(PULSE_BAT_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .supply_ok_i(supply_ok_i),
  .wdog_en_i(wdog_en_i), .bat_mode_i(bat_mode_i), .pend_o(pend_o),
  .rst_req_n_o(rst_req_n_o)
);

// File: tb/smart_rst_wdog_tb_top.sv
module smart_rst_wdog_tb_top;
  localparam int SET = 20;
  localparam int HLD = 200;
  localparam int GRD = 10;
  localparam int PSU = 5;
  localparam int PBA = 10;

  // {bat_mode, request offset k (-1 none), expected pend-to-pulse edges, expected width}
  localparam int VEC [0:6][0:3] = '{
    '{0, -1, HLD, PSU},
    '{1, -1, HLD, PBA},
    '{0, 50, 53, PSU},
    '{1, 0, 3, PBA},
    '{0, HLD-4, HLD-1, PSU},
    '{0, HLD-3, HLD, PSU},
    '{1, HLD-2, HLD, PBA}
  };

  logic clk, rst_n, tick, supply_ok, req_clr, wdog_en, bat_mode;
  logic pend_o, rst_req_n_o;
  logic slow_tick;
  int   checks, fails;
  bit   done;

  smart_rst_wdog #(
    .SETTLE_TICKS(SET), .HOLD_TICKS(HLD), .GUARD_TICKS(GRD),
    .PULSE_SUP_TICKS(PSU), .PULSE_BAT_TICKS(PBA), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .supply_ok_i(supply_ok),
    .req_clr_i(req_clr), .wdog_en_i(wdog_en), .bat_mode_i(bat_mode),
    .pend_o(pend_o), .rst_req_n_o(rst_req_n_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) tick <= slow_tick ? ~tick : 1'b1;

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic wait_out(input bit on_rst, input logic val, input int lim, output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (((on_rst ? rst_req_n_o : pend_o) !== val) && n < lim);
  endtask

  task automatic quiet(input int cyc, output int bad);
    bad = 0;
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk); #1;
      if (pend_o || !rst_req_n_o) bad++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n, k, bad;
    checks = 0; fails = 0; done = 0;
    rst_n = 0; supply_ok = 0; req_clr = 0; wdog_en = 0; bat_mode = 0;
    slow_tick = 0; tick = 1;
    repeat (3) @(posedge clk); #1;
    chk("R1 pend in reset", int'(pend_o), 0);
    chk("R1 rst in reset", int'(rst_req_n_o), 1);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    chk("R1 pend after release", int'(pend_o), 0);
    chk("R1 rst after release", int'(rst_req_n_o), 1);

    // R2 R3 R4 R5: one-shot vectors
    for (int v = 0; v < 7; v++) begin
      @(negedge clk); bat_mode = VEC[v][0] != 0; supply_ok = 1;
      wait_out(0, 1'b1, 1000, n);
      chk("R2 settle edges", n, SET + 1);
      k = VEC[v][1];
      if (k >= 0) begin
        repeat (k) @(posedge clk);
        @(negedge clk) req_clr = 1;
        wait_out(1, 1'b0, 1000, n);
        n += k;
      end else begin
        wait_out(1, 1'b0, 1000, n);
      end
      chk("R3 pend-to-pulse edges", n, VEC[v][2]);
      chk("R4 pend low at pulse", int'(pend_o), 0);
      wait_out(1, 1'b1, 1000, n);
      chk("R5 pulse width", n, VEC[v][3]);
      @(negedge clk) req_clr = 0;
      quiet(2 * HLD, bad);
      chk("R4 single pulse per plug-in", bad, 0);
      @(negedge clk) supply_ok = 0;
      repeat (3) @(posedge clk);
    end

    // R2: unplug during settle restarts it
    @(negedge clk) supply_ok = 1; bat_mode = 0;
    repeat (10) @(posedge clk);
    @(negedge clk) supply_ok = 0;
    quiet(30, bad);
    chk("R2 aborted settle keeps pend low", bad, 0);
    @(negedge clk) supply_ok = 1;
    wait_out(0, 1'b1, 1000, n);
    chk("R2 full settle after replug", n, SET + 1);
    // R10: pulling supply while pending
    @(negedge clk) supply_ok = 0;
    @(posedge clk); #1;
    chk("R10 pend drops with supply", int'(pend_o), 0);
    repeat (3) @(posedge clk);

    // R9: sparse ticks stretch the settle interval
    @(negedge clk) slow_tick = 1;
    repeat (2) @(posedge clk);
    @(negedge clk) supply_ok = 1;
    wait_out(0, 1'b1, 1000, n);
    chk("R9 half-rate settle within bounds", int'(n == 2*SET || n == 2*SET + 1), 1);
    @(negedge clk) supply_ok = 0; slow_tick = 0;
    repeat (3) @(posedge clk);

    // R6: watchdog in battery mode
    @(negedge clk) wdog_en = 1; bat_mode = 1;
    wait_out(0, 1'b1, 1000, n);
    chk("R6 enable to pend edges", n, 2);
    wait_out(1, 1'b0, 1000, n);
    chk("R6 watchdog period", n, HLD);
    wait_out(1, 1'b1, 1000, n);
    chk("R5 battery width in watchdog", n, PBA);
    chk("R6 pend back high at release", int'(pend_o), 1);
    @(negedge clk) bat_mode = 0;
    wait_out(1, 1'b0, 1000, n);
    chk("R6 second period", n, HLD);
    wait_out(1, 1'b1, 1000, n);

    // R7: clear at the last allowed count restarts the interval
    k = HLD - GRD - 2;
    repeat (k) @(posedge clk);
    @(negedge clk) req_clr = 1;
    repeat (4) @(posedge clk);
    @(negedge clk) req_clr = 0;
    wait_out(1, 1'b0, 2000, n);
    chk("R7 accepted clear delays pulse", n + k + 4, k + 3 + HLD);
    wait_out(1, 1'b1, 1000, n);
    // R7: clear one count later is ignored
    k = HLD - GRD - 1;
    repeat (k) @(posedge clk);
    @(negedge clk) req_clr = 1;
    wait_out(1, 1'b0, 2000, n);
    chk("R7 late clear ignored", n + k, HLD);
    @(negedge clk) req_clr = 0;
    wait_out(1, 1'b1, 1000, n);

    // R8: disable without supply
    @(negedge clk) wdog_en = 0;
    @(posedge clk); #1;
    chk("R8 pend drops on disable", int'(pend_o), 0);
    quiet(50, bad);
    chk("R8 no activity without supply", bad, 0);
    // R8: disable with supply starts a fresh settle
    @(negedge clk) supply_ok = 1; wdog_en = 1;
    wait_out(0, 1'b1, 1000, n);
    chk("R6 enable with supply present", n, 2);
    repeat (5) @(posedge clk);
    @(negedge clk) wdog_en = 0;
    wait_out(0, 1'b1, 1000, n);
    chk("R8 settle after disable", n, SET + 2);
    wait_out(1, 1'b0, 1000, n);
    chk("R8 one-shot hold after disable", n, HLD);

    repeat (20) @(posedge clk);
    finish_run();
  end
endmodule